// File: doc/BRIEF.md
# DMA Function State Controller

This block is the control and status face of a memory-to-memory DMA function. It presents six 64-bit registers on a simple read/write port. Software writes a 2-bit state request into the command register and polls the status register to see the lifecycle state. The states are stopped, initializing, active, soft stopping, hard stopping and error.

Two inputs stand in for the datapath. `work_pending_i` holds a soft stop open until it drops. `err_i` forces any running state into error. Error can only be left with a reset request. The block also returns fixed capability and version words. It holds a limits register that software may program only while the function is stopped, and every field written there is clamped to the matching capability.

Reads are combinational from `reg_addr_i`. A write takes effect on the clock edge where `reg_wr_i` is sampled high. The state change it causes is visible right after that edge.

Top module: `dma_fn_state_ctrl`

## Requirements
- R1: After reset the state is stopped (0). The command register and the limits register both read 0.
- R2: Offset 0x200 reads the stride exponent in bits [22:20] and zero elsewhere. Offset 0x208 reads buffer code [3:0], key-size code [15:12], maximum context [31:16] and operation-group bitmap [63:32]. Offset 0x210 reads minor [7:0] = 0 and major [23:16] = 1. Unmapped offsets read 0.
- R3: An activate request (code 3) while stopped moves the state to initializing (1). Initializing moves to active (2) after exactly INIT_CYCLES cycles.
- R4: A soft-stop request (code 1) in initializing or active moves the state to soft stopping (3). It stays there while `work_pending_i` is high, and reaches stopped one cycle after it is seen low.
- R5: A hard-stop request (code 2) in soft stopping moves the state to hard stopping (4). This wins over a drain that finishes in the same cycle. Hard stopping reaches stopped after exactly DRAIN_CYCLES cycles, whatever `work_pending_i` is.
- R6: `err_i` high in any state other than stopped moves the state to error (5) on the next edge, overriding any request. In stopped it has no effect.
- R7: Error is left only by a reset request (code 0), which returns the state to stopped. A reset request while stopped keeps it stopped.
- R8: A request that is not legal in the current state leaves the state unchanged.
- R9: A write to offset 0x010 is accepted only while stopped. The buffer, key-size and context fields are each limited to the capability value. The group field is ANDed with the capability bitmap. Bits [11:4] read 0.
- R10: Offset 0x000 reads back the last written request in bits [1:0]. Offset 0x100 reports the state in bits [2:0]: 0 stopped, 1 initializing, 2 active, 3 soft stopping, 4 hard stopping, 5 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Byte offset of the register accessed |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for `reg_addr_i` |
| err_i | input | 1 | Error injection from the datapath |
| work_pending_i | input | 1 | Outstanding work still in flight |
| state_o | output | 3 | Current lifecycle state |

## Verification
The assertions check the following on every cycle:
- activate from stopped and entry into error;
- that error holds until a reset request arrives;
- that soft stopping holds while work is pending;
- the hard-stop drain bound;
- that the state encoding stays legal;
- that the limits register stays frozen outside stopped and always stays within the capabilities.

Only the bench scenarios can show the exact dwell times in initializing and hard stopping, and the clamped values read back. They also show that illegal requests and error pulses in stopped have no effect at the ports. A behavioural reference model tracks state and every register read on each clock.

// File: rtl/dma_fn_pkg.sv
package dma_fn_pkg;
  typedef enum logic [2:0] {
    ST_STOP   = 3'd0,
    ST_INIT   = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_SOFT   = 3'd3,
    ST_HARD   = 3'd4,
    ST_ERR    = 3'd5
  } fn_state_e;

  typedef enum logic [1:0] {
    REQ_RESET = 2'd0,
    REQ_SOFT  = 2'd1,
    REQ_HARD  = 2'd2,
    REQ_ACT   = 2'd3
  } fn_req_e;

  localparam int unsigned OFF_CMD    = 'h000;
  localparam int unsigned OFF_LIMITS = 'h010;
  localparam int unsigned OFF_STATUS = 'h100;
  localparam int unsigned OFF_CAPA   = 'h200;
  localparam int unsigned OFF_CAPB   = 'h208;
  localparam int unsigned OFF_VER    = 'h210;
endpackage

// File: rtl/dma_fn_fsm.sv
module dma_fn_fsm
  import dma_fn_pkg::*;
#(
  parameter int unsigned INIT_CYCLES  = 4,
  parameter int unsigned DRAIN_CYCLES = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_valid_i,
  input  logic [1:0] req_i,
  input  logic      err_i,
  input  logic      work_i,
  output fn_state_e state_o
);
  localparam int unsigned MAXC = (INIT_CYCLES > DRAIN_CYCLES) ? INIT_CYCLES : DRAIN_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] INIT_LAST  = CW'(INIT_CYCLES - 1);
  localparam logic [CW-1:0] DRAIN_LAST = CW'(DRAIN_CYCLES - 1);

  fn_state_e st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic req_rst, req_soft, req_hard, req_act;

  assign req_rst  = req_valid_i && (req_i == REQ_RESET);
  assign req_soft = req_valid_i && (req_i == REQ_SOFT);
  assign req_hard = req_valid_i && (req_i == REQ_HARD);
  assign req_act  = req_valid_i && (req_i == REQ_ACT);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_STOP:   if (req_act) st_d = ST_INIT;
      ST_INIT:   if (req_soft) st_d = ST_SOFT;
                 else if (cnt_q == INIT_LAST) st_d = ST_ACTIVE;
      ST_ACTIVE: if (req_soft) st_d = ST_SOFT;
      ST_SOFT:   if (req_hard) st_d = ST_HARD;       // hard request beats drain
                 else if (!work_i) st_d = ST_STOP;
      ST_HARD:   if (cnt_q == DRAIN_LAST) st_d = ST_STOP;
      ST_ERR:    if (req_rst) st_d = ST_STOP;
      default:   st_d = ST_STOP;
    endcase
    if (err_i && st_q != ST_STOP) st_d = ST_ERR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_STOP;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q) cnt_q <= '0;
      else if (st_q == ST_INIT || st_q == ST_HARD) cnt_q <= cnt_q + 1'b1;
      else cnt_q <= '0;
    end
  end

  assign state_o = st_q;

  p_stop_act_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_STOP && req_act |=> st_q == ST_INIT);
  p_soft_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_SOFT && work_i && !err_i && !req_hard |=> st_q == ST_SOFT);
  p_drain_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_HARD |-> cnt_q < DRAIN_CYCLES);
  p_err_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i && st_q != ST_STOP |=> st_q == ST_ERR);
  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_ERR && !req_rst |=> st_q == ST_ERR);
  p_stop_stays_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_STOP && !req_act |=> st_q == ST_STOP);
  p_state_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q <= ST_ERR);
endmodule

// File: rtl/dma_fn_limits.sv
module dma_fn_limits
  import dma_fn_pkg::*;
#(
  parameter logic [3:0]  CAP_BUF = 4'd9,
  parameter logic [3:0]  CAP_KEY = 4'd5,
  parameter logic [15:0] CAP_CXT = 16'h00ff,
  parameter logic [31:0] CAP_OPG = 32'h0000_000b
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  buf_i,
  input  logic [3:0]  key_i,
  input  logic [15:0] cxt_i,
  input  logic [31:0] opg_i,
  input  fn_state_e   state_i,
  output logic [63:0] limits_o
);
  logic [3:0]  buf_q, key_q;
  logic [15:0] cxt_q;
  logic [31:0] opg_q;
  logic        accept;

  assign accept = wr_i && (state_i == ST_STOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      key_q <= '0;
      cxt_q <= '0;
      opg_q <= '0;
    end else if (accept) begin
      buf_q <= (buf_i > CAP_BUF) ? CAP_BUF : buf_i;
      key_q <= (key_i > CAP_KEY) ? CAP_KEY : key_i;
      cxt_q <= (cxt_i > CAP_CXT) ? CAP_CXT : cxt_i;
      opg_q <= opg_i & CAP_OPG;
    end
  end

  assign limits_o = {opg_q, cxt_q, key_q, 8'h00, buf_q};

  p_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != ST_STOP |=> $stable(limits_o));
  p_clamped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limits_o[3:0] <= CAP_BUF && limits_o[15:12] <= CAP_KEY &&
    limits_o[31:16] <= CAP_CXT && (limits_o[63:32] & ~CAP_OPG) == '0);
endmodule

// File: rtl/dma_fn_state_ctrl.sv
module dma_fn_state_ctrl
  import dma_fn_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned INIT_CYCLES  = 4,
  parameter int unsigned DRAIN_CYCLES = 3,
  parameter logic [2:0]  STRIDE_EXP   = 3'd2,
  parameter logic [3:0]  CAP_BUF      = 4'd9,
  parameter logic [3:0]  CAP_KEY      = 4'd5,
  parameter logic [15:0] CAP_CXT      = 16'h00ff,
  parameter logic [31:0] CAP_OPG      = 32'h0000_000b,
  parameter logic [7:0]  VER_MAJOR    = 8'd1,
  parameter logic [7:0]  VER_MINOR    = 8'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  input  logic              err_i,
  input  logic              work_pending_i,
  output logic [2:0]        state_o
);
  localparam logic [63:0] CAPA_WORD = {41'd0, STRIDE_EXP, 20'd0};
  localparam logic [63:0] CAPB_WORD = {CAP_OPG, CAP_CXT, CAP_KEY, 8'h00, CAP_BUF};
  localparam logic [63:0] VER_WORD  = {40'd0, VER_MAJOR, 8'h00, VER_MINOR};

  logic        cmd_wr, lim_wr;
  logic [1:0]  cmd_q;
  logic [63:0] limits;
  fn_state_e   state;
  logic        unused_wdata;

  assign cmd_wr = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_CMD));
  assign lim_wr = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_LIMITS));
  assign unused_wdata = ^reg_wdata_i[11:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= '0;
    else if (cmd_wr) cmd_q <= reg_wdata_i[1:0];
  end

  dma_fn_fsm #(
    .INIT_CYCLES (INIT_CYCLES),
    .DRAIN_CYCLES(DRAIN_CYCLES)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(cmd_wr),
    .req_i      (reg_wdata_i[1:0]),
    .err_i      (err_i),
    .work_i     (work_pending_i),
    .state_o    (state)
  );

  dma_fn_limits #(
    .CAP_BUF(CAP_BUF),
    .CAP_KEY(CAP_KEY),
    .CAP_CXT(CAP_CXT),
    .CAP_OPG(CAP_OPG)
  ) i_limits (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (lim_wr),
    .buf_i   (reg_wdata_i[3:0]),
    .key_i   (reg_wdata_i[15:12]),
    .cxt_i   (reg_wdata_i[31:16]),
    .opg_i   (reg_wdata_i[63:32]),
    .state_i (state),
    .limits_o(limits)
  );

  always_comb begin
    reg_rdata_o = '0;
    if      (reg_addr_i == ADDR_W'(OFF_CMD))    reg_rdata_o = {62'd0, cmd_q};
    else if (reg_addr_i == ADDR_W'(OFF_LIMITS)) reg_rdata_o = limits;
    else if (reg_addr_i == ADDR_W'(OFF_STATUS)) reg_rdata_o = {61'd0, state};
    else if (reg_addr_i == ADDR_W'(OFF_CAPA))   reg_rdata_o = CAPA_WORD;
    else if (reg_addr_i == ADDR_W'(OFF_CAPB))   reg_rdata_o = CAPB_WORD;
    else if (reg_addr_i == ADDR_W'(OFF_VER))    reg_rdata_o = VER_WORD;
  end

  assign state_o = state;

  p_status_mirror_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && reg_wdata_i[1:0] == 2'd3 && state_o == 3'd0 |=> state_o == 3'd1);
endmodule

// File: tb/test_dma_fn_state_ctrl.sv
`timescale 1ns/100ps
module test_dma_fn_state_ctrl;
  localparam int INIT_C  = 4;
  localparam int DRAIN_C = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic [63:0] wdata = '0;
  logic        err = 1'b0;
  logic        work = 1'b0;
  logic [63:0] rdata;
  logic [2:0]  state;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  int          m_st = 0;
  int          m_cnt = 0;
  logic [1:0]  m_cmd = '0;
  logic [63:0] m_lim = '0;

  always #2 clk = ~clk;

  dma_fn_state_ctrl #(.INIT_CYCLES(INIT_C), .DRAIN_CYCLES(DRAIN_C)) i_dma_fn_state_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .err_i(err),
    .work_pending_i(work), .state_o(state)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_read(input logic [11:0] a);
    case (a)
      12'h000: return {62'd0, m_cmd};
      12'h010: return m_lim;
      12'h100: return 64'(m_st);
      12'h200: return 64'h0000_0000_0020_0000;
      12'h208: return 64'h0000_000b_00ff_5009;
      12'h210: return 64'h0000_0000_0001_0000;
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [3:0] lim4(input logic [3:0] v, input logic [3:0] c);
    return (v > c) ? c : v;
  endfunction

  task automatic model_step();
    bit rv = wr && addr == 12'h000;
    int rq = int'(wdata[1:0]);
    int nx = m_st;
    case (m_st)
      0: if (rv && rq == 3) nx = 1;
      1: if (rv && rq == 1) nx = 3; else if (m_cnt == INIT_C - 1) nx = 2;
      2: if (rv && rq == 1) nx = 3;
      3: if (rv && rq == 2) nx = 4; else if (!work) nx = 0;
      4: if (m_cnt == DRAIN_C - 1) nx = 0;
      5: if (rv && rq == 0) nx = 0;
      default: nx = 0;
    endcase
    if (err && m_st != 0) nx = 5;
    if (wr && addr == 12'h010 && m_st == 0) begin
      m_lim = '0;
      m_lim[3:0]   = lim4(wdata[3:0], 4'd9);
      m_lim[15:12] = lim4(wdata[15:12], 4'd5);
      m_lim[31:16] = (wdata[31:16] > 16'h00ff) ? 16'h00ff : wdata[31:16];
      m_lim[63:32] = wdata[63:32] & 32'h0000_000b;
    end
    if (rv) m_cmd = wdata[1:0];
    m_cnt = (nx != m_st) ? 0 : m_cnt + 1;
    m_st = nx;
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    #1;
    chk(cur_req, 64'(state), 64'(m_st));
    chk(cur_req, rdata, model_read(addr));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wreg(input logic [11:0] a, input logic [63:0] d);
    addr = a; wdata = d; wr = 1'b1;
    cycle();
    wr = 1'b0; addr = 12'h100;
  endtask

  task automatic peek(input string req, input logic [11:0] a, input logic [63:0] exp);
    addr = a;
    #0.5;
    chk(req, rdata, exp);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    peek("R1", 12'h100, 64'd0);
    peek("R1", 12'h000, 64'd0);
    peek("R1", 12'h010, 64'd0);
    // R2 fixed words and holes
    peek("R2", 12'h200, 64'h0000_0000_0020_0000);
    peek("R2", 12'h208, 64'h0000_000b_00ff_5009);
    peek("R2", 12'h210, 64'h0000_0000_0001_0000);
    peek("R2", 12'h018, 64'd0);
    peek("R2", 12'h300, 64'd0);
    // R8 illegal while stopped; R10 command readback
    cur_req = "R8";
    wreg(12'h000, 64'd1);
    wreg(12'h000, 64'd2);
    chk("R8", 64'(state), 64'd0);
    peek("R10", 12'h000, 64'd2);
    // R9 clamping while stopped
    cur_req = "R9";
    wreg(12'h010, '1);
    peek("R9", 12'h010, 64'h0000_000b_00ff_5009);
    wreg(12'h010, 64'h0000_f0f1_0010_2ff3);
    peek("R9", 12'h010, 64'h0000_0001_0010_2003);
    // R3 activate and init dwell
    cur_req = "R3";
    wreg(12'h000, 64'd3);
    chk("R3", 64'(state), 64'd1);
    idle(INIT_C - 1);
    chk("R3", 64'(state), 64'd1);
    idle(1);
    chk("R3", 64'(state), 64'd2);
    peek("R10", 12'h100, 64'd2);
    // R9 write ignored while active
    cur_req = "R9";
    wreg(12'h010, 64'd0);
    peek("R9", 12'h010, 64'h0000_0001_0010_2003);
    // R8 illegal while active
    cur_req = "R8";
    wreg(12'h000, 64'd3);
    wreg(12'h000, 64'd2);
    wreg(12'h000, 64'd0);
    chk("R8", 64'(state), 64'd2);
    // R4 soft stop held by work
    cur_req = "R4";
    work = 1'b1;
    wreg(12'h000, 64'd1);
    chk("R4", 64'(state), 64'd3);
    idle(10);
    chk("R4", 64'(state), 64'd3);
    work = 1'b0;
    idle(1);
    chk("R4", 64'(state), 64'd0);
    // R5 hard stop drains regardless of work
    cur_req = "R5";
    wreg(12'h000, 64'd3);
    idle(INIT_C);
    work = 1'b1;
    wreg(12'h000, 64'd1);
    work = 1'b0;
    wreg(12'h000, 64'd2);
    chk("R5", 64'(state), 64'd4);
    work = 1'b1;
    idle(DRAIN_C - 1);
    chk("R5", 64'(state), 64'd4);
    idle(1);
    chk("R5", 64'(state), 64'd0);
    work = 1'b0;
    // R4 soft stop from initializing
    cur_req = "R4";
    wreg(12'h000, 64'd3);
    wreg(12'h000, 64'd1);
    chk("R4", 64'(state), 64'd3);
    idle(1);
    chk("R4", 64'(state), 64'd0);
    // R6 error ignored while stopped
    cur_req = "R6";
    err = 1'b1;
    idle(2);
    chk("R6", 64'(state), 64'd0);
    err = 1'b0;
    wreg(12'h000, 64'd3);
    err = 1'b1;
    wreg(12'h000, 64'd1);
    chk("R6", 64'(state), 64'd5);
    // R7 error held with reset while err high, illegal requests ignored
    cur_req = "R7";
    wreg(12'h000, 64'd0);
    chk("R7", 64'(state), 64'd5);
    err = 1'b0;
    wreg(12'h000, 64'd3);
    wreg(12'h000, 64'd1);
    wreg(12'h000, 64'd2);
    chk("R7", 64'(state), 64'd5);
    wreg(12'h000, 64'd0);
    chk("R7", 64'(state), 64'd0);
    wreg(12'h000, 64'd0);
    chk("R7", 64'(state), 64'd0);
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule